// File: doc/BRIEF.md
# CAN Transmit Arbitration Scheduler

This block chooses which pending transmit queue hands its next message to a CAN protocol engine, and keeps count of retransmission attempts for every queue. Each queue has a request bit, a 5-bit priority and a retry policy. Queue 0 is special: it orders its messages by lowest identifier. Every other queue sends its messages strictly in load order. The message contents stay in an external message memory. The scheduler only tracks slot occupancy, and identifiers for queue 0. It presents a queue and slot to that memory and reads back the data length code of the chosen message.

After each grant, the block compares the message length against the queue's reserved payload before it offers the message to the engine. A message that does not fit is dropped and flagged. While a message is with the engine, the grant stays fixed until the engine reports success, error or lost arbitration. The scheduler then updates the request bit, the attempt count and the sticky flags, and picks again from scratch. Each success also emits a one-cycle event for a transmit-event logger.

Top module: `can_tx_sched`

## Requirements
- R1: Among eligible queues (request bit set and at least one message loaded), the queue with the numerically largest priority field is granted; 31 is the highest priority and 0 the lowest.
- R2: When eligible queues share the highest priority, the lower queue index is granted.
- R3: In queues 1 to NQ-1, loads fill slots 0,1,...,DEPTH-1 and then wrap to 0; messages are granted in that same order.
- R4: In queue 0, a load takes the lowest-numbered free slot, and the valid slot holding the numerically smallest identifier is granted first.
- R5: Once a message is offered (tx_valid high), tx_queue and tx_slot hold until eng_done, even if a higher-priority request or a lower identifier arrives meanwhile; the next choice is made after each completion.
- R6: On eng_result 01 (success), the queue's ok flag is set, the message is removed, and evt_valid pulses for one cycle (the cycle after eng_done) with evt_queue naming the queue; the request bit clears only when that queue becomes empty.
- R7: retry_cfg per queue: 00 allows one attempt, 01 allows three attempts, 10 or 11 retries without limit; every eng_result 10 (error) sets the queue's err flag.
- R8: When an error uses the last allowed attempt, the exh flag is set, the request bit clears, and the message stays queued; exh, err, ok and inv flags stay set until the matching flag_clr bit is high.
- R9: eng_result 11 (lost arbitration) uses no attempt and sets no flag.
- R10: sel_dlc codes 0-8 mean that many bytes, and codes 9-15 mean 12,16,20,24,32,48,64 bytes. psize_cfg codes 0-7 mean 8,12,16,20,24,32,48,64 bytes. A granted message whose length exceeds its queue's payload is never offered: it is removed, inv flag and dlc_mm are set, and the request bit clears.
- R11: After reset, all request bits and flags are clear, tx_valid and evt_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_set | input | NQ | Per-queue request set pulse |
| load | input | NQ | Per-queue message-loaded pulse |
| load_id | input | ID_W | Identifier of a message loaded into queue 0 |
| prio_cfg | input | NQ*5 | Per-queue priority, 5 bits each |
| retry_cfg | input | NQ*2 | Per-queue retry policy, 2 bits each |
| psize_cfg | input | NQ*3 | Per-queue payload size code, 3 bits each |
| sel_dlc | input | 4 | Length code of the message at tx_queue/tx_slot |
| tx_valid | output | 1 | Message offered to the engine |
| tx_queue | output | QW | Granted queue |
| tx_slot | output | SW | Granted slot within the queue |
| eng_done | input | 1 | Engine completion strobe |
| eng_result | input | 2 | 01 success, 10 error, 11 lost arbitration |
| flag_clr | input | NQ | Per-queue flag clear |
| dlc_mm_clr | input | 1 | Clears dlc_mm |
| req_bits | output | NQ | Request bits |
| ok_flags | output | NQ | Success flags |
| err_flags | output | NQ | Error flags |
| exh_flags | output | NQ | Attempts-exhausted flags |
| inv_flags | output | NQ | Invalid-message flags |
| dlc_mm | output | 1 | Length-mismatch flag |
| evt_valid | output | 1 | One-cycle success event |
| evt_queue | output | QW | Queue of the success event |

## Verification
The assertions check on every cycle that a grant stays fixed while the engine works and that only a queue whose request bit is set is offered. They also check that every success event follows a successful completion of the same queue and lasts one cycle, that lost arbitration leaves the error and exhausted flags alone, and that exhausted flags never drop without a clear. The bench scenarios cover the rest: priority order and tie-breaking, FIFO and lowest-identifier order, the attempt counts of each retry policy, the message staying queued after exhaustion, and the length-rejection path.

// File: rtl/can_txs_pkg.sv
package can_txs_pkg;

  typedef enum logic [1:0] {ST_SEL, ST_CHK, ST_BUSY} txs_state_e;

  localparam logic [1:0] RES_OK   = 2'b01;
  localparam logic [1:0] RES_ERR  = 2'b10;
  localparam logic [1:0] RES_LOST = 2'b11;

  // Bytes carried by a length code
  function automatic logic [6:0] dlc_bytes(input logic [3:0] d);
    logic [6:0] b;
    case (d)
      4'd9:    b = 7'd12;
      4'd10:   b = 7'd16;
      4'd11:   b = 7'd20;
      4'd12:   b = 7'd24;
      4'd13:   b = 7'd32;
      4'd14:   b = 7'd48;
      4'd15:   b = 7'd64;
      default: b = {3'b000, d};
    endcase
    return b;
  endfunction

  // Bytes reserved by a payload code
  function automatic logic [6:0] psize_bytes(input logic [2:0] c);
    logic [6:0] b;
    case (c)
      3'd0:    b = 7'd8;
      3'd1:    b = 7'd12;
      3'd2:    b = 7'd16;
      3'd3:    b = 7'd20;
      3'd4:    b = 7'd24;
      3'd5:    b = 7'd32;
      3'd6:    b = 7'd48;
      default: b = 7'd64;
    endcase
    return b;
  endfunction

  function automatic logic len_fits(input logic [3:0] d, input logic [2:0] c);
    return dlc_bytes(d) <= psize_bytes(c);
  endfunction

  // Allowed attempts for a policy; 0 means no limit
  function automatic logic [1:0] attempt_limit(input logic [1:0] pol);
    logic [1:0] l;
    case (pol)
      2'b00:   l = 2'd1;
      2'b01:   l = 2'd3;
      default: l = 2'd0;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/txs_fifo_ctl.sv
module txs_fifo_ctl #(
  parameter int DEPTH = 4,
  parameter int SW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          pop,
  output logic [CW-1:0] cnt,
  output logic [SW-1:0] head
);
  logic [SW-1:0] rd_q;
  logic          load_ok;

  assign load_ok = load && (cnt != CW'(DEPTH));
  assign head    = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      cnt  <= '0;
    end else begin
      if (pop) rd_q <= (rd_q == SW'(DEPTH - 1)) ? '0 : rd_q + SW'(1);
      cnt <= cnt + CW'(load_ok) - CW'(pop);
    end
  end
endmodule

// File: rtl/txs_idq.sv
module txs_idq #(
  parameter int DEPTH = 4,
  parameter int ID_W  = 11,
  parameter int SW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [ID_W-1:0] load_id,
  input  logic            pop,
  input  logic [SW-1:0]   pop_slot,
  output logic [CW-1:0]   cnt,
  output logic [SW-1:0]   head
);
  logic [DEPTH-1:0] valid_q;
  logic [ID_W-1:0]  ids_q [DEPTH];
  logic             free_found;
  logic [SW-1:0]    free_s;
  logic             head_found;
  logic [ID_W-1:0]  head_id;

  always_comb begin
    free_found = 1'b0;
    free_s     = '0;
    for (int s = 0; s < DEPTH; s++) begin
      if (!valid_q[s] && !free_found) begin
        free_found = 1'b1;
        free_s     = SW'(s);
      end
    end
  end

  always_comb begin
    head_found = 1'b0;
    head_id    = '0;
    head       = '0;
    for (int s = 0; s < DEPTH; s++) begin
      if (valid_q[s] && (!head_found || ids_q[s] < head_id)) begin
        head_found = 1'b1;
        head_id    = ids_q[s];
        head       = SW'(s);
      end
    end
  end

  assign cnt = CW'($countones(valid_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int s = 0; s < DEPTH; s++) ids_q[s] <= '0;
    end else begin
      if (pop) valid_q[pop_slot] <= 1'b0;
      if (load && free_found) begin
        valid_q[free_s] <= 1'b1;
        ids_q[free_s]   <= load_id;
      end
    end
  end
endmodule

// File: rtl/txs_pick.sv
module txs_pick #(
  parameter int NQ     = 8,
  parameter int PRIO_W = 5,
  parameter int QW     = $clog2(NQ)
) (
  input  logic [NQ-1:0]        elig,
  input  logic [NQ*PRIO_W-1:0] prio,
  output logic                 any,
  output logic [QW-1:0]        win
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    any  = 1'b0;
    win  = '0;
    best = '0;
    for (int q = 0; q < NQ; q++) begin
      if (elig[q] && (!any || prio[q*PRIO_W +: PRIO_W] > best)) begin
        any  = 1'b1;
        best = prio[q*PRIO_W +: PRIO_W];
        win  = QW'(q);
      end
    end
  end
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
  import can_txs_pkg::*;
#(
  parameter int NQ     = 8,
  parameter int DEPTH  = 4,
  parameter int ID_W   = 11,
  parameter int PRIO_W = 5,
  parameter int QW     = $clog2(NQ),
  parameter int SW     = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NQ-1:0]        req_set,
  input  logic [NQ-1:0]        load,
  input  logic [ID_W-1:0]      load_id,
  input  logic [NQ*PRIO_W-1:0] prio_cfg,
  input  logic [NQ*2-1:0]      retry_cfg,
  input  logic [NQ*3-1:0]      psize_cfg,
  input  logic [3:0]           sel_dlc,
  output logic                 tx_valid,
  output logic [QW-1:0]        tx_queue,
  output logic [SW-1:0]        tx_slot,
  input  logic                 eng_done,
  input  logic [1:0]           eng_result,
  input  logic [NQ-1:0]        flag_clr,
  input  logic                 dlc_mm_clr,
  output logic [NQ-1:0]        req_bits,
  output logic [NQ-1:0]        ok_flags,
  output logic [NQ-1:0]        err_flags,
  output logic [NQ-1:0]        exh_flags,
  output logic [NQ-1:0]        inv_flags,
  output logic                 dlc_mm,
  output logic                 evt_valid,
  output logic [QW-1:0]        evt_queue
);
  localparam int CW = $clog2(DEPTH + 1);

  txs_state_e    state_q;
  logic [QW-1:0] grant_q;
  logic [SW-1:0] grant_s;
  logic [CW-1:0] cnt   [NQ];
  logic [SW-1:0] head  [NQ];
  logic [1:0]    att_q [NQ];
  logic [NQ-1:0] elig;
  logic [NQ-1:0] pop_v;
  logic          pick_any;
  logic [QW-1:0] pick_win;

  // Named events
  logic       done_v, ev_ok, ev_err, ev_lost, ev_rej, ev_exh, last_msg;
  logic [1:0] cur_lim;
  logic [2:0] att_next;

  assign done_v   = (state_q == ST_BUSY) && eng_done;
  assign ev_ok    = done_v && (eng_result == RES_OK);
  assign ev_err   = done_v && (eng_result == RES_ERR);
  assign ev_lost  = done_v && (eng_result == RES_LOST);
  assign ev_rej   = (state_q == ST_CHK) && !len_fits(sel_dlc, psize_cfg[grant_q*3 +: 3]);
  assign cur_lim  = attempt_limit(retry_cfg[grant_q*2 +: 2]);
  assign att_next = {1'b0, att_q[grant_q]} + 3'd1;
  assign ev_exh   = ev_err && (cur_lim != 2'd0) && (att_next == {1'b0, cur_lim});
  assign last_msg = (cnt[grant_q] == CW'(1)) && !load[grant_q];

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      elig[q]  = req_bits[q] && (cnt[q] != '0);
      pop_v[q] = (ev_ok || ev_rej) && (grant_q == QW'(q));
    end
  end

  genvar gq;
  generate
    for (gq = 0; gq < NQ; gq++) begin : g_q
      if (gq == 0) begin : g_id
        txs_idq #(.DEPTH(DEPTH), .ID_W(ID_W), .SW(SW), .CW(CW)) u_idq (
          .clk(clk), .rst_n(rst_n), .load(load[gq]), .load_id(load_id),
          .pop(pop_v[gq]), .pop_slot(grant_s), .cnt(cnt[gq]), .head(head[gq])
        );
      end else begin : g_fifo
        txs_fifo_ctl #(.DEPTH(DEPTH), .SW(SW), .CW(CW)) u_fifo (
          .clk(clk), .rst_n(rst_n), .load(load[gq]), .pop(pop_v[gq]),
          .cnt(cnt[gq]), .head(head[gq])
        );
      end
    end
  endgenerate

  txs_pick #(.NQ(NQ), .PRIO_W(PRIO_W), .QW(QW)) u_pick (
    .elig(elig), .prio(prio_cfg), .any(pick_any), .win(pick_win)
  );

  // Grant state machine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEL;
      grant_q <= '0;
      grant_s <= '0;
    end else begin
      case (state_q)
        ST_SEL: if (pick_any) begin
          grant_q <= pick_win;
          grant_s <= head[pick_win];
          state_q <= ST_CHK;
        end
        ST_CHK:  state_q <= ev_rej ? ST_SEL : ST_BUSY;
        ST_BUSY: if (eng_done) state_q <= ST_SEL;
        default: state_q <= ST_SEL;
      endcase
    end
  end

  // Per-queue request bits, attempts and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_bits  <= '0;
      ok_flags  <= '0;
      err_flags <= '0;
      exh_flags <= '0;
      inv_flags <= '0;
      for (int q = 0; q < NQ; q++) att_q[q] <= '0;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (req_set[q]) req_bits[q] <= 1'b1;
        else if ((grant_q == QW'(q)) && ((ev_ok && last_msg) || ev_rej || ev_exh))
          req_bits[q] <= 1'b0;

        if (grant_q == QW'(q)) begin
          if (ev_ok || ev_rej || ev_exh) att_q[q] <= '0;
          else if (ev_err && cur_lim != 2'd0) att_q[q] <= att_next[1:0];
        end

        if ((grant_q == QW'(q)) && ev_ok)       ok_flags[q] <= 1'b1;
        else if (flag_clr[q])                   ok_flags[q] <= 1'b0;
        if ((grant_q == QW'(q)) && ev_err)      err_flags[q] <= 1'b1;
        else if (flag_clr[q])                   err_flags[q] <= 1'b0;
        if ((grant_q == QW'(q)) && ev_exh)      exh_flags[q] <= 1'b1;
        else if (flag_clr[q])                   exh_flags[q] <= 1'b0;
        if ((grant_q == QW'(q)) && ev_rej)      inv_flags[q] <= 1'b1;
        else if (flag_clr[q])                   inv_flags[q] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlc_mm    <= 1'b0;
      evt_valid <= 1'b0;
      evt_queue <= '0;
    end else begin
      if (ev_rej) dlc_mm <= 1'b1;
      else if (dlc_mm_clr) dlc_mm <= 1'b0;
      evt_valid <= ev_ok;
      if (ev_ok) evt_queue <= grant_q;
    end
  end

  assign tx_valid = (state_q == ST_BUSY);
  assign tx_queue = grant_q;
  assign tx_slot  = grant_s;

  logic unused_ev;
  assign unused_ev = ev_lost;

endmodule

// File: rtl/txs_chk.sv
module txs_chk #(
  parameter int NQ = 8,
  parameter int QW = 3,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic [QW-1:0] tx_queue,
  input logic [SW-1:0] tx_slot,
  input logic          eng_done,
  input logic [1:0]    eng_result,
  input logic [NQ-1:0] req_bits,
  input logic [NQ-1:0] err_flags,
  input logic [NQ-1:0] exh_flags,
  input logic [NQ-1:0] flag_clr,
  input logic          evt_valid,
  input logic [QW-1:0] evt_queue
);
  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !eng_done) |=> (tx_valid && $stable(tx_queue) && $stable(tx_slot)));

  // R1
  grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> req_bits[tx_queue]);

  // R6
  evt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> ($past(tx_valid && eng_done && eng_result == 2'b01) && evt_queue == $past(tx_queue)));

  // R6
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);

  // R9
  lost_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && eng_done && eng_result == 2'b11 && flag_clr == '0) |=>
      ($stable(err_flags) && $stable(exh_flags)));

  // R8
  exh_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(exh_flags) & ~$past(flag_clr)) & ~exh_flags) == '0));
endmodule

bind can_tx_sched txs_chk #(.NQ(NQ), .QW(QW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_queue(tx_queue),
  .tx_slot(tx_slot), .eng_done(eng_done), .eng_result(eng_result),
  .req_bits(req_bits), .err_flags(err_flags), .exh_flags(exh_flags),
  .flag_clr(flag_clr), .evt_valid(evt_valid), .evt_queue(evt_queue)
);

// File: tb/tb_can_tx_sched.sv
module tb_can_tx_sched;
  localparam int NQ = 8, DEPTH = 4, ID_W = 11, QW = 3, SW = 2;
  localparam int ENG_LAT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NQ-1:0]   req_set = '0, load = '0, flag_clr = '0;
  logic [ID_W-1:0] load_id = '0;
  logic [NQ*5-1:0] prio_cfg = '0;
  logic [NQ*2-1:0] retry_cfg = {NQ{2'b10}};
  logic [NQ*3-1:0] psize_cfg = {NQ{3'd7}};
  logic [3:0]      sel_dlc;
  logic            dlc_mm_clr = 1'b0;
  logic            eng_done = 1'b0;
  logic [1:0]      eng_result = 2'b00;
  logic            tx_valid, dlc_mm, evt_valid;
  logic [QW-1:0]   tx_queue, evt_queue;
  logic [SW-1:0]   tx_slot;
  logic [NQ-1:0]   req_bits, ok_flags, err_flags, exh_flags, inv_flags;

  can_tx_sched #(.NQ(NQ), .DEPTH(DEPTH), .ID_W(ID_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .load(load), .load_id(load_id),
    .prio_cfg(prio_cfg), .retry_cfg(retry_cfg), .psize_cfg(psize_cfg),
    .sel_dlc(sel_dlc), .tx_valid(tx_valid), .tx_queue(tx_queue), .tx_slot(tx_slot),
    .eng_done(eng_done), .eng_result(eng_result), .flag_clr(flag_clr),
    .dlc_mm_clr(dlc_mm_clr), .req_bits(req_bits), .ok_flags(ok_flags),
    .err_flags(err_flags), .exh_flags(exh_flags), .inv_flags(inv_flags),
    .dlc_mm(dlc_mm), .evt_valid(evt_valid), .evt_queue(evt_queue)
  );

  // Message memory model: length code per queue and slot
  logic [3:0] dlc_mem [NQ][DEPTH];
  assign sel_dlc = dlc_mem[tx_queue][tx_slot];

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  logic [1:0] res_q[$];
  int wptr [NQ];
  bit occ0 [DEPTH];
  int last_grant = 0;
  bit saw_q1 = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // Driver tasks
  task automatic cfg(input int q, input int pr, input logic [1:0] pol, input logic [2:0] ps);
    @(negedge clk);
    prio_cfg[q*5 +: 5] = pr[4:0];
    retry_cfg[q*2 +: 2] = pol;
    psize_cfg[q*3 +: 3] = ps;
  endtask

  task automatic load_msg(input int q, input int id, input logic [3:0] dlc);
    int s;
    @(negedge clk);
    if (q == 0) begin
      s = 0;
      for (int i = DEPTH - 1; i >= 0; i--) if (!occ0[i]) s = i;
      occ0[s] = 1'b1;
    end else begin
      s = wptr[q];
      wptr[q] = (wptr[q] + 1) % DEPTH;
    end
    dlc_mem[q][s] = dlc;
    load[q] = 1'b1;
    load_id = id[ID_W-1:0];
    @(negedge clk);
    load = '0;
  endtask

  task automatic set_req(input logic [NQ-1:0] m);
    @(negedge clk);
    req_set = m;
    @(negedge clk);
    req_set = '0;
  endtask

  task automatic expect_tx(input int q, input int s);
    exp_q.push_back(q * 16 + s);
  endtask

  task automatic wait_quiet(input string tag);
    int quiet = 0;
    int t = 0;
    while (quiet < 4 && t < 3000) begin
      @(negedge clk);
      t++;
      if (exp_q.size() == 0 && res_q.size() == 0 && !tx_valid && !eng_done) quiet++;
      else quiet = 0;
    end
    chk(quiet >= 4, tag, exp_q.size(), 0);
  endtask

  // Behavioural protocol engine
  initial begin
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (tx_valid) begin
        repeat (ENG_LAT - 1) @(negedge clk);
        eng_result = (res_q.size() != 0) ? res_q.pop_front() : 2'b01;
        last_grant = int'(tx_queue) * 16 + int'(tx_slot);
        eng_done = 1'b1;
      end
    end
  end

  // Monitor: compares success events against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (tx_valid && tx_queue == 3'd1) saw_q1 = 1'b1;
      if (evt_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected event", int'(evt_queue), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk((int'(evt_queue) == e / 16) && (last_grant == e),
              "R1/R2/R3/R4/R6 grant order", int'(evt_queue) * 256 + last_grant, (e / 16) * 256 + e);
          if (e / 16 == 0) occ0[e % 16] = 1'b0;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin
      wptr[q] = 0;
      for (int s = 0; s < DEPTH; s++) dlc_mem[q][s] = 4'd8;
    end
    for (int s = 0; s < DEPTH; s++) occ0[s] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(req_bits == '0 && ok_flags == '0 && err_flags == '0, "R11 reset flags", int'(req_bits), 0);
    chk(exh_flags == '0 && inv_flags == '0 && !dlc_mm, "R11 reset sticky", int'(exh_flags), 0);
    chk(!tx_valid && !evt_valid, "R11 reset outputs", int'(tx_valid), 0);

    // R1 R2: priorities 5, 20, 20
    cfg(2, 5, 2'b10, 3'd7);
    cfg(5, 20, 2'b10, 3'd7);
    cfg(3, 20, 2'b10, 3'd7);
    load_msg(2, 0, 4'd8);
    load_msg(5, 0, 4'd8);
    load_msg(3, 0, 4'd8);
    expect_tx(3, 0);
    expect_tx(5, 0);
    expect_tx(2, 0);
    set_req(8'b0010_1100);
    wait_quiet("R1 drain");
    chk(req_bits == '0, "R6 request cleared when empty", int'(req_bits), 0);
    chk(ok_flags == 8'b0010_1100, "R6 ok flags", int'(ok_flags), 8'h2c);

    // R3 FIFO order
    cfg(1, 12, 2'b10, 3'd7);
    load_msg(1, 0, 4'd8);
    load_msg(1, 0, 4'd8);
    load_msg(1, 0, 4'd8);
    expect_tx(1, 0);
    expect_tx(1, 1);
    expect_tx(1, 2);
    set_req(8'b0000_0010);
    wait_quiet("R3 drain");

    // R4 lowest identifier first in queue 0
    cfg(0, 31, 2'b10, 3'd7);
    load_msg(0, 'h300, 4'd8);
    load_msg(0, 'h100, 4'd8);
    load_msg(0, 'h200, 4'd8);
    expect_tx(0, 1);
    expect_tx(0, 2);
    expect_tx(0, 0);
    set_req(8'b0000_0001);
    wait_quiet("R4 drain");

    // R5 higher request during transmission does not abort; re-pick after completion
    cfg(4, 10, 2'b10, 3'd7);
    cfg(6, 30, 2'b10, 3'd7);
    load_msg(4, 0, 4'd8);
    load_msg(4, 0, 4'd8);
    expect_tx(4, 0);
    expect_tx(6, 0);
    expect_tx(4, 1);
    set_req(8'b0001_0000);
    while (!(tx_valid && tx_queue == 3'd4)) @(negedge clk);
    load_msg(6, 0, 4'd8);
    set_req(8'b0100_0000);
    while (!(evt_valid && evt_queue == 3'd4)) @(negedge clk);
    chk(req_bits[4] == 1'b1, "R6 request held while messages remain", int'(req_bits[4]), 1);
    wait_quiet("R5 drain");

    // R7 R8 three-attempt policy
    cfg(7, 15, 2'b01, 3'd7);
    res_q.push_back(2'b10);
    res_q.push_back(2'b10);
    res_q.push_back(2'b10);
    load_msg(7, 0, 4'd8);
    set_req(8'b1000_0000);
    wait_quiet("R8 three errors");
    chk(exh_flags[7] && err_flags[7], "R8 exhausted after three", int'(exh_flags), 'h80);
    chk(!req_bits[7] && !ok_flags[7], "R8 request cleared", int'(req_bits), 0);
    expect_tx(7, 0);
    set_req(8'b1000_0000);
    wait_quiet("R8 message kept");
    chk(exh_flags[7], "R8 exhausted flag sticky", int'(exh_flags[7]), 1);

    // R7 single-attempt policy
    cfg(2, 5, 2'b00, 3'd7);
    res_q.push_back(2'b10);
    load_msg(2, 0, 4'd8);
    set_req(8'b0000_0100);
    wait_quiet("R7 one error");
    chk(exh_flags[2] && !req_bits[2], "R7 single attempt exhausts", int'(exh_flags), 'h04);
    expect_tx(2, 1);
    set_req(8'b0000_0100);
    wait_quiet("R7 resend");

    // R7 unlimited policy
    for (int i = 0; i < 4; i++) res_q.push_back(2'b10);
    load_msg(5, 0, 4'd8);
    expect_tx(5, 1);
    set_req(8'b0010_0000);
    wait_quiet("R7 unlimited");
    chk(!exh_flags[5] && err_flags[5], "R7 unlimited never exhausts", int'(exh_flags[5]), 0);

    // R9 lost arbitration uses no attempt
    cfg(3, 20, 2'b01, 3'd7);
    for (int i = 0; i < 3; i++) res_q.push_back(2'b11);
    res_q.push_back(2'b10);
    res_q.push_back(2'b10);
    load_msg(3, 0, 4'd8);
    expect_tx(3, 1);
    set_req(8'b0000_1000);
    wait_quiet("R9 lost");
    chk(!exh_flags[3] && err_flags[3], "R9 lost arbitration not counted", int'(exh_flags[3]), 0);

    // R10 length larger than payload
    cfg(1, 12, 2'b10, 3'd0);
    saw_q1 = 1'b0;
    load_msg(1, 0, 4'd9);
    load_msg(1, 0, 4'd8);
    set_req(8'b0000_0010);
    wait_quiet("R10 reject");
    chk(inv_flags[1] && dlc_mm, "R10 invalid flags", int'(inv_flags), 'h02);
    chk(!req_bits[1] && !saw_q1, "R10 not offered, request cleared", int'(saw_q1), 0);
    expect_tx(1, 0);
    set_req(8'b0000_0010);
    wait_quiet("R10 next message");

    // R8 software clear
    @(negedge clk);
    flag_clr = '1;
    dlc_mm_clr = 1'b1;
    @(negedge clk);
    flag_clr = '0;
    dlc_mm_clr = 1'b0;
    @(negedge clk);
    chk(exh_flags == '0 && err_flags == '0 && ok_flags == '0 && inv_flags == '0 && !dlc_mm,
        "R8 flags cleared", int'(exh_flags), 0);

    done_flag = 1'b1;
    summary();
    $finish;
  end
endmodule